// File: doc/BRIEF.md
# RGB Pixel Word Unpacker

This block sits between a pixel FIFO and the data pins of a parallel LCD panel. It takes 32-bit words through a valid/ready handshake, holds one word at a time, and emits pixels as 24-bit bus values. It emits a pixel only in cycles where the timing generator raises its pixel-enable strobe. Two pixel formats are handled. In the 16-bit format each word carries two RGB565 pixels. In the 24-bit format each word carries one 8:8:8 pixel in its low three bytes. A 24-bit pixel can also be narrowed to an 18-bit panel by keeping only the low six bits of each colour component.

A per-byte enable mask zeroes the byte lanes of the word that do not hold pixel data, before the word is unpacked. Four configuration inputs set the format: word length, byte mask, truncation flag and panel bus width. They are expected to stay static while pixels are flowing. If the word length and bus width form an unsupported pair, an error flag goes high and the block goes quiet.

Top module: `lcd_pixel_unpack`

## Requirements
- R1: After reset, with a supported configuration, no pixel is pending: pix_valid is 0, pix_data is 0 and word_ready is 1.
- R2: word_ready is 1 exactly when the configuration is supported and either no word is held, or the last pixel of the held word is consumed in that same cycle. A word taken in 16-bit mode therefore blocks the next word until both of its pixels have gone out.
- R3: With cfg_wlen = 0 (16-bit pixels), each word gives two pixels. Bits 15:0 go out first and bits 31:16 second. Each pixel appears on pix_data[15:0], with red in 15:11, green in 10:5 and blue in 4:0, and pix_data[23:16] is 0.
- R4: With cfg_wlen = 3 (24-bit pixels), each word gives one pixel, and pix_data[23:0] equals word bits 23:0: red in 23:16, green in 15:8, blue in 7:0.
- R5: With cfg_wlen = 3 and cfg_trunc18 = 1, pix_data[17:0] is {red[5:0], green[5:0], blue[5:0]} and pix_data[23:18] is 0. In 16-bit mode cfg_trunc18 has no effect.
- R6: When bit i of cfg_byte_en is 0, byte i of the word (bits 8i+7:8i) reads as zero before unpacking.
- R7: pix_valid is 1 only in cycles where pix_en is 1. While pix_en is 0, the pending pixel is held and not lost, and pixels come out in word order.
- R8: cfg_err is 1 when cfg_wlen is 1 or 2, or when cfg_wlen is 3 and cfg_bus is 0 (the 8-bit panel). The cfg_bus codes are 0 = 8-bit, 1 = 16-bit, 2 = 18-bit, 3 = 24-bit. While cfg_err is 1, pix_valid, pix_data and word_ready are all 0.
- R9: pix_data is 0 in every cycle where pix_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wlen | input | 2 | Word length code: 0 = 16-bit pixels, 3 = 24-bit pixels |
| cfg_byte_en | input | 4 | Valid byte lanes of each word |
| cfg_trunc18 | input | 1 | Narrow 24-bit pixels to 6 bits per component |
| cfg_bus | input | 2 | Panel bus width code: 0 = 8, 1 = 16, 2 = 18, 3 = 24 bits |
| word_valid | input | 1 | A word from the FIFO is offered |
| word_data | input | 32 | Offered word |
| word_ready | output | 1 | The block accepts the offered word at this edge |
| pix_en | input | 1 | Pixel strobe from the timing generator |
| pix_valid | output | 1 | pix_data holds a pixel in this cycle |
| pix_data | output | 24 | Pixel value on the panel bus |
| cfg_err | output | 1 | Unsupported word-length and bus-width pair |

## Verification
The assertions take for granted that the four configuration inputs change only while reset is held. The bench keeps to this: it applies each configuration under reset and does not touch it until the next reset. The assertions also assume that pix_en comes from a timing source that may stay low for any number of cycles. The random stimulus therefore drives both the word offer and the strobe with independent random duty cycles. Directed cases cover the held-word back-pressure, a long stall of the strobe, a sparse byte mask, and every unsupported configuration pair.

// File: rtl/lcd_unpack_pkg.sv
`timescale 1ns/1ps
// Package: shared codes and widths for the pixel word unpacker.
// Assumes a word of whole bytes and a colour component of at most one byte.
package lcd_unpack_pkg;

    // Word-length codes as seen on cfg_wlen
    typedef enum logic [1:0] {
        WL_PIX16  = 2'd0,
        WL_RSVD1  = 2'd1,
        WL_RSVD2  = 2'd2,
        WL_PIX24  = 2'd3
    } wlen_e;

    // Panel bus-width codes as seen on cfg_bus
    typedef enum logic [1:0] {
        PBUS_8  = 2'd0,
        PBUS_16 = 2'd1,
        PBUS_18 = 2'd2,
        PBUS_24 = 2'd3
    } pbus_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/lcd_unpack_cfg_check.sv
`timescale 1ns/1ps
// Module: lcd_unpack_cfg_check
// Decodes whether the word-length and bus-width pair is supported.
// Assumes the configuration is static while pixels flow.
module lcd_unpack_cfg_check
    import lcd_unpack_pkg::*;
(
    input  logic [1:0] wlen,
    input  logic [1:0] bus,
    output logic       err
);

    // Purpose: flag reserved word lengths and 24-bit pixels on an 8-bit bus
    always_comb begin
        unique case (wlen_e'(wlen))
            WL_PIX16: err = 1'b0;
            WL_PIX24: err = (pbus_e'(bus) == PBUS_8);
            default:  err = 1'b1;
        endcase
    end

endmodule

// File: rtl/lcd_unpack_hold.sv
`timescale 1ns/1ps
// Module: lcd_unpack_hold
// One-word holding register with a pixel-slot counter.
// Assumes load and consume are never both requested unless consume takes the
// last slot; the load then wins and restarts the slot count.
module lcd_unpack_hold #(
    parameter int WORD_W   = 32,
    parameter int SLOTS    = 2,
    localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              consume,
    input  logic              last,
    output logic [WORD_W-1:0] word_q,
    output logic              full_q,
    output logic [SLOT_W-1:0] slot_q
);

    // Purpose: capture a new word or advance through its pixel slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            full_q <= 1'b0;
            slot_q <= '0;
        end else if (load) begin
            word_q <= load_word;
            full_q <= 1'b1;
            slot_q <= '0;
        end else if (consume) begin
            if (last) begin
                full_q <= 1'b0;
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_unpack_format.sv
`timescale 1ns/1ps
// Module: lcd_unpack_format
// Masks the byte lanes of the held word and arranges one pixel on the bus.
// Assumes 16-bit pixels are 5:6:5 and 24-bit pixels are 8:8:8, low bytes used.
module lcd_unpack_format
    import lcd_unpack_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int PIX_W   = 24,
    parameter int NARROW  = 6,
    localparam int NBYTES = WORD_W / BYTE_W,
    localparam int HALF_W = WORD_W / 2,
    localparam int NCH    = 3
) (
    input  logic [WORD_W-1:0] word_q,
    input  logic [NBYTES-1:0] byte_en,
    input  logic [1:0]        wlen,
    input  logic              trunc,
    input  logic              slot,
    output logic [PIX_W-1:0]  px
);

    logic [WORD_W-1:0] masked;
    logic [HALF_W-1:0] half;
    logic [NCH*NARROW-1:0] narrow;

    // Purpose: zero every byte lane whose enable bit is clear
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign masked[b*BYTE_W +: BYTE_W] = byte_en[b] ? word_q[b*BYTE_W +: BYTE_W]
                                                        : '0;
    end

    // Purpose: keep the low bits of each 8-bit component for a narrow panel
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign narrow[c*NARROW +: NARROW] = masked[c*BYTE_W +: NARROW];
    end

    // Purpose: choose the halfword for the current slot, low half first
    always_comb begin
        half = slot ? masked[WORD_W-1:HALF_W] : masked[HALF_W-1:0];
    end

    // Purpose: place the selected pixel on the bus for the word length
    always_comb begin
        px = '0;
        unique case (wlen_e'(wlen))
            WL_PIX16: px[HALF_W-1:0] = half;
            WL_PIX24: begin
                if (trunc) px[NCH*NARROW-1:0] = narrow;
                else       px[NCH*BYTE_W-1:0] = masked[NCH*BYTE_W-1:0];
            end
            default:  px = '0;
        endcase
    end

endmodule

// File: rtl/lcd_pixel_unpack.sv
`timescale 1ns/1ps
// Module: lcd_pixel_unpack (top)
// Unpacks FIFO words into pixels, one per pixel strobe.
// Assumes configuration inputs change only while reset is held.
module lcd_pixel_unpack
    import lcd_unpack_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int PIX_W   = 24,
    parameter int NARROW  = 6,
    localparam int NBYTES = WORD_W / BYTE_W,
    localparam int SLOTS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_wlen,
    input  logic [NBYTES-1:0] cfg_byte_en,
    input  logic              cfg_trunc18,
    input  logic [1:0]        cfg_bus,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              pix_en,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    output logic              cfg_err
);

    logic              err;
    logic [WORD_W-1:0] held;
    logic              full;
    logic              slot;
    logic              fire;
    logic              last;
    logic              load;
    logic [PIX_W-1:0]  px;

    lcd_unpack_cfg_check u_cfg (
        .wlen (cfg_wlen),
        .bus  (cfg_bus),
        .err  (err)
    );

    // Purpose: decide pixel issue, last-slot and word acceptance
    always_comb begin
        fire       = full & ~err & pix_en;
        last       = (wlen_e'(cfg_wlen) == WL_PIX24) | slot;
        word_ready = ~err & (~full | (fire & last));
        load       = word_valid & word_ready;
    end

    lcd_unpack_hold #(
        .WORD_W (WORD_W),
        .SLOTS  (SLOTS)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (word_data),
        .consume   (fire),
        .last      (last),
        .word_q    (held),
        .full_q    (full),
        .slot_q    (slot)
    );

    lcd_unpack_format #(
        .WORD_W (WORD_W),
        .PIX_W  (PIX_W),
        .NARROW (NARROW)
    ) u_fmt (
        .word_q  (held),
        .byte_en (cfg_byte_en),
        .wlen    (cfg_wlen),
        .trunc   (cfg_trunc18),
        .slot    (slot),
        .px      (px)
    );

    // Purpose: drive the bus only for an issued pixel, zero otherwise
    always_comb begin
        pix_valid = fire;
        pix_data  = fire ? px : '0;
        cfg_err   = err;
    end

endmodule

// File: rtl/lcd_pixel_unpack_chk.sv
`timescale 1ns/1ps
// Module: lcd_pixel_unpack_chk
// Port-level properties of the unpacker, attached by bind.
// Assumes configuration is static outside reset.
module lcd_pixel_unpack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_wlen,
    input logic        cfg_trunc18,
    input logic        word_ready,
    input logic        pix_en,
    input logic        pix_valid,
    input logic [23:0] pix_data,
    input logic        cfg_err
);

    AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> pix_en); // R7

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!pix_valid && !word_ready && pix_data == 24'd0)); // R8

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> pix_data == 24'd0); // R9

    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cfg_wlen == 2'd3 && cfg_trunc18) |-> pix_data[23:18] == 6'd0); // R5

    AST_HALF_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cfg_wlen == 2'd0) |-> pix_data[23:16] == 8'd0); // R3

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> !pix_valid); // R1

endmodule

bind lcd_pixel_unpack lcd_pixel_unpack_chk u_chk (.*);

// File: tb/lcd_pixel_unpack_tb.sv
`timescale 1ns/1ps
module lcd_pixel_unpack_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_wlen = 2'd0;
    logic [3:0]  cfg_byte_en = 4'hF;
    logic        cfg_trunc18 = 1'b0;
    logic [1:0]  cfg_bus = 2'd1;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = 32'd0;
    logic        word_ready;
    logic        pix_en = 1'b0;
    logic        pix_valid;
    logic [23:0] pix_data;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    logic [23:0] expq[$];
    string tag = "R3";

    always #2 clk = ~clk;

    lcd_pixel_unpack u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wlen(cfg_wlen), .cfg_byte_en(cfg_byte_en),
        .cfg_trunc18(cfg_trunc18), .cfg_bus(cfg_bus),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .pix_en(pix_en), .pix_valid(pix_valid), .pix_data(pix_data),
        .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected pixels for one accepted word, from R3..R6
    function automatic void push_exp(input logic [31:0] w);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = cfg_byte_en[b] ? w[b*8 +: 8] : 8'd0;
        if (cfg_wlen == 2'd0) begin
            expq.push_back({8'd0, m[15:0]});
            expq.push_back({8'd0, m[31:16]});
        end else if (cfg_trunc18) begin
            expq.push_back({6'd0, m[21:16], m[13:8], m[5:0]});
        end else begin
            expq.push_back(m[23:0]);
        end
    endfunction

    task automatic do_reset(input logic [1:0] wl, input logic [3:0] be,
                            input logic tr, input logic [1:0] bw);
        @(negedge clk);
        rst_n = 1'b0; word_valid = 1'b0; pix_en = 1'b0;
        cfg_wlen = wl; cfg_byte_en = be; cfg_trunc18 = tr; cfg_bus = bw;
        expq.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive at the falling edge, then sample what the next rise sees
    task automatic cycle(input logic wv, input logic [31:0] wd, input logic pe);
        @(negedge clk);
        word_valid = wv; word_data = wd; pix_en = pe;
        #1;
        if (pix_valid && !pix_en) check("R7 valid without strobe", 32'd1, 32'd0);
        if (!pix_valid && pix_data != 24'd0) check("R9 idle bus", {8'd0, pix_data}, 32'd0);
        if (pix_valid) begin
            if (expq.size() == 0) check("R7 unexpected pixel", {8'd0, pix_data}, 32'hFFFFFFFF);
            else check(tag, {8'd0, pix_data}, {8'd0, expq.pop_front()});
        end
        if (wv && word_ready) push_exp(wd);
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++) cycle(1'b0, 32'd0, 1'b1);
        check("R7 all pixels delivered", expq.size(), 32'd0);
    endtask

    task automatic random_run(input logic [1:0] wl, input logic [3:0] be,
                              input logic tr, input logic [1:0] bw, input string t);
        do_reset(wl, be, tr, bw);
        tag = t;
        for (int i = 0; i < 2000; i++)
            cycle(($urandom % 4) != 0, $urandom, ($urandom % 3) != 0);
        drain();
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));

        // R1: reset state
        do_reset(2'd0, 4'hF, 1'b0, 2'd1);
        #1;
        check("R1 pix_valid", pix_valid, 0);
        check("R1 pix_data", pix_data, 0);
        check("R1 word_ready", word_ready, 1);
        check("R1 cfg_err", cfg_err, 0);

        // R2/R3: back-pressure across both halves of a 16-bit word
        tag = "R3 halfword order";
        cycle(1'b1, 32'hABCD_1234, 1'b0);
        cycle(1'b0, 32'd0, 1'b0);
        check("R2 ready low while word held", word_ready, 0);
        cycle(1'b0, 32'd0, 1'b1);
        check("R2 ready low on first half", word_ready, 0);
        cycle(1'b0, 32'd0, 1'b1);
        check("R2 ready high on last half", word_ready, 1);
        drain();

        // R7: long stall keeps the pending pixel
        do_reset(2'd3, 4'h7, 1'b0, 2'd3);
        tag = "R4 after stall";
        cycle(1'b1, 32'h5566_7788, 1'b0);
        for (int i = 0; i < 10; i++) cycle(1'b1, 32'h0102_0304, 1'b0);
        check("R7 no output while strobe low", pix_valid, 0);
        drain();

        // R6: sparse byte mask in 24-bit mode
        do_reset(2'd3, 4'h5, 1'b0, 2'd3);
        tag = "R6 sparse mask";
        cycle(1'b1, 32'hFFEE_DDCC, 1'b1);
        cycle(1'b0, 32'd0, 1'b1);
        drain();

        // R5: narrowing of a known pixel
        do_reset(2'd3, 4'h7, 1'b1, 2'd2);
        tag = "R5 narrow";
        cycle(1'b1, 32'h00FF_C381, 1'b1);
        cycle(1'b0, 32'd0, 1'b1);
        drain();

        // R8: every unsupported pair
        for (int k = 0; k < 3; k++) begin
            if (k == 0) do_reset(2'd1, 4'hF, 1'b0, 2'd1);
            else if (k == 1) do_reset(2'd2, 4'hF, 1'b0, 2'd3);
            else do_reset(2'd3, 4'h7, 1'b0, 2'd0);
            tag = "R8 pixel under error";
            cycle(1'b1, 32'h1234_5678, 1'b1);
            check("R8 cfg_err", cfg_err, 1);
            check("R8 word_ready", word_ready, 0);
            check("R8 pix_valid", pix_valid, 0);
            check("R8 pix_data", pix_data, 0);
        end

        // Random runs over the supported modes
        random_run(2'd0, 4'hF, 1'b0, 2'd1, "R3 random 16-bit");
        random_run(2'd0, 4'hF, 1'b1, 2'd2, "R5 flag ignored in 16-bit");
        random_run(2'd3, 4'h7, 1'b0, 2'd3, "R4 random 24-bit");
        random_run(2'd3, 4'h7, 1'b1, 2'd2, "R5 random narrow");
        random_run(2'd3, 4'h7, 1'b1, 2'd1, "R5 narrow on 16-bit bus");
        random_run(2'd3, 4'hB, 1'b0, 2'd3, "R6 random mask 24-bit");
        random_run(2'd0, 4'h6, 1'b0, 2'd3, "R6 random mask 16-bit");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule